// File: doc/BRIEF.md
# Decimal Partial Product Generator

This block forms one partial product of a decimal multiplication. It takes a multiplicand of `DIGITS` BCD digits and a single BCD multiplier digit. It returns the product of the two in radix-10 carry-save form: a BCD sum vector one digit wider than the multiplicand, and a carry vector with one bit per digit position. Carry bit `i` has weight 10^i, the same weight as sum digit `i`.

The multiplier digit is split into a coarse part of 0, 5 or 10 and a fine part in the range -2 to +2. Only two multiples of the multiplicand have to be prepared, twice and five times the multiplicand, and both are built digit by digit with no ripple across the word. Ten times the multiplicand is a one-digit shift. A negative fine part is added as the nines' complement of its multiple, with the missing unit entered through carry bit 0. The value of the outputs is therefore the product modulo 10^(DIGITS+1). Because the product is at most nine times the multiplicand, it always fits in that range.

The block is purely combinational, with no clock or handshake. A multiplier tree places one instance per multiplier digit and adds up the carry-save results.

Top module: `dec_ppgen`

## Requirements
- R1: For multiplier digits 0 to 9, the sum of pp_sum digit i × 10^i and pp_carry bit i × 10^i, taken modulo 10^(DIGITS+1), equals x × digit. Four rows weighted by 1, 10, 100 and 1000 therefore rebuild 1963 × 8145 = 15988635.
- R2: Every 4-bit digit of pp_sum lies in 0..9 for any BCD multiplicand and any digit value.
- R3: pp_carry bit 0 is 1 exactly when the multiplier digit is 3, 4, 8 or 9. These are the digits whose fine part is negative.
- R4: Multiplier digit 0 drives every bit of pp_sum and pp_carry to 0.
- R5: Multiplier digit 5 drives pp_carry to all zeros. pp_sum digit i then equals floor(x digit i-1 / 2) + 5 × (x digit i mod 2), where x digit -1 and x digit DIGITS are taken as 0.
- R6: Multiplier digit 1 drives pp_carry to all zeros, and pp_sum equals the multiplicand with a 0 in its top digit.
- R7: Multiplier digit codes 10 to 15 are not valid decimal digits. They produce all-zero pp_sum and pp_carry.
- R8: Multiplier digit 2 drives pp_carry to all zeros, and pp_sum equals 2x exactly. This holds when every multiplicand digit is 9.
- R9: With a zero multiplicand and digit 8 or 9, pp_sum is all nines and pp_carry is 1 only at bit 0. Their value wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_bcd | input | 4*DIGITS | Multiplicand, BCD, digit 0 in bits 3:0 |
| y_digit | input | 4 | Multiplier digit, BCD |
| pp_sum | output | 4*(DIGITS+1) | Carry-save sum digits, digit 0 in bits 3:0 |
| pp_carry | output | DIGITS+1 | Carry-save carry bits, bit i has weight 10^i |

## Verification
The bench goes after the recode boundaries at 3 and 8. A wrong coarse/fine split there would give a value off by a multiple of x, and a wrongly placed complement unit would leave the result one short. An all-nines multiplicand tests the doubling carry into the next digit. If that carry were lost or allowed to ripple further, digit values above 9 or a wrong 2x would appear. An all-zero multiplicand with a negative fine part checks the wrap through the top digit, which a missing nines pad in the top digit would break. Invalid digit codes and odd/even neighbour pairs for the five-times multiple complete the set. A mistake in the half-digit shift would misplace the 5 contributions.

// File: rtl/dec_ppgen_pkg.sv
package dec_ppgen_pkg;
  typedef enum logic [1:0] {
    HI_NONE = 2'd0,
    HI_FIVE = 2'd1,
    HI_TEN  = 2'd2
  } hi_sel_e;
endpackage

// File: rtl/dec_ppgen_recode.sv
module dec_ppgen_recode
  import dec_ppgen_pkg::*;
(
  input  logic [3:0] digit,
  output hi_sel_e    hi_sel,
  output logic [1:0] lo_mag,
  output logic       lo_neg
);
  always_comb begin
    hi_sel = HI_NONE;
    lo_mag = 2'd0;
    lo_neg = 1'b0;
    case (digit)
      4'd1: lo_mag = 2'd1;
      4'd2: lo_mag = 2'd2;
      4'd3: begin hi_sel = HI_FIVE; lo_mag = 2'd2; lo_neg = 1'b1; end
      4'd4: begin hi_sel = HI_FIVE; lo_mag = 2'd1; lo_neg = 1'b1; end
      4'd5: hi_sel = HI_FIVE;
      4'd6: begin hi_sel = HI_FIVE; lo_mag = 2'd1; end
      4'd7: begin hi_sel = HI_FIVE; lo_mag = 2'd2; end
      4'd8: begin hi_sel = HI_TEN;  lo_mag = 2'd2; lo_neg = 1'b1; end
      4'd9: begin hi_sel = HI_TEN;  lo_mag = 2'd1; lo_neg = 1'b1; end
      default: ;
    endcase
  end

  // fine part never negative with zero magnitude, and coarse code is legal
  always_comb begin
    if (!$isunknown(digit)) begin
      p_recode_legal_r3: assert (!(lo_neg && lo_mag == 2'd0) && hi_sel != 2'd3)
        else $error("recode produced an illegal pair");
    end
  end
endmodule

// File: rtl/dec_ppgen_multiples.sv
module dec_ppgen_multiples #(
  parameter int DIGITS = 16
) (
  input  logic [4*DIGITS-1:0]     x_bcd,
  output logic [4*(DIGITS+1)-1:0] x_ext,
  output logic [4*(DIGITS+1)-1:0] x_dbl,
  output logic [4*(DIGITS+1)-1:0] x_five,
  output logic [4*(DIGITS+1)-1:0] x_ten
);
  localparam int W = DIGITS + 1;

  assign x_ext = {4'd0, x_bcd};
  assign x_ten = {x_bcd, 4'd0};

  for (genvar i = 0; i < W; i++) begin : g_dig
    logic [3:0] cur;
    logic [3:0] prev;
    logic [4:0] twice;
    logic [3:0] dbl_low;
    logic       dbl_cin;
    assign cur = x_ext[4*i +: 4];
    if (i == 0) begin : g_lsd
      assign prev = 4'd0;
    end else begin : g_upper
      assign prev = x_ext[4*(i-1) +: 4];
    end
    assign twice   = {cur, 1'b0};
    assign dbl_low = (twice >= 5'd10) ? (twice[3:0] + 4'd6) : twice[3:0];
    assign dbl_cin = (prev >= 4'd5);
    // low digit of a doubling is even (<=8), so adding the carry never overflows
    assign x_dbl[4*i +: 4]  = dbl_low + {3'd0, dbl_cin};
    assign x_five[4*i +: 4] = {1'b0, prev[3:1]} + (cur[0] ? 4'd5 : 4'd0);
  end

  always_comb begin
    if (!$isunknown(x_bcd)) begin
      for (int i = 0; i < W; i++) begin
        p_mult_digits_r2: assert (x_dbl[4*i +: 4] <= 4'd9 && x_five[4*i +: 4] <= 4'd9)
          else $error("multiple digit above nine");
      end
    end
  end
endmodule

// File: rtl/dec_ppgen_select.sv
module dec_ppgen_select
  import dec_ppgen_pkg::*;
#(
  parameter int DIGITS = 16
) (
  input  hi_sel_e                 hi_sel,
  input  logic [1:0]              lo_mag,
  input  logic                    lo_neg,
  input  logic [4*(DIGITS+1)-1:0] x_ext,
  input  logic [4*(DIGITS+1)-1:0] x_dbl,
  input  logic [4*(DIGITS+1)-1:0] x_five,
  input  logic [4*(DIGITS+1)-1:0] x_ten,
  output logic [4*(DIGITS+1)-1:0] hi_term,
  output logic [4*(DIGITS+1)-1:0] lo_term
);
  localparam int W = DIGITS + 1;

  for (genvar i = 0; i < W; i++) begin : g_dig
    logic [3:0] lo_raw;
    always_comb begin
      case (hi_sel)
        HI_FIVE: hi_term[4*i +: 4] = x_five[4*i +: 4];
        HI_TEN:  hi_term[4*i +: 4] = x_ten[4*i +: 4];
        default: hi_term[4*i +: 4] = 4'd0;
      endcase
      case (lo_mag)
        2'd1:    lo_raw = x_ext[4*i +: 4];
        2'd2:    lo_raw = x_dbl[4*i +: 4];
        default: lo_raw = 4'd0;
      endcase
      lo_term[4*i +: 4] = lo_neg ? (4'd9 - lo_raw) : lo_raw;
    end
  end
endmodule

// File: rtl/dec_ppgen_csa.sv
module dec_ppgen_csa #(
  parameter int DIGITS = 16
) (
  input  logic [4*(DIGITS+1)-1:0] a_in,
  input  logic [4*(DIGITS+1)-1:0] b_in,
  input  logic                    c_in,
  output logic [4*(DIGITS+1)-1:0] s_out,
  output logic [DIGITS:0]         c_out
);
  localparam int W = DIGITS + 1;

  assign c_out[0] = c_in;

  for (genvar i = 0; i < W; i++) begin : g_dig
    logic [4:0] raw;
    logic       wrap;
    assign raw  = {1'b0, a_in[4*i +: 4]} + {1'b0, b_in[4*i +: 4]};
    assign wrap = (raw >= 5'd10);
    assign s_out[4*i +: 4] = wrap ? (raw[3:0] + 4'd6) : raw[3:0];
    if (i < W - 1) begin : g_cy
      assign c_out[i+1] = wrap;
    end
  end

  always_comb begin
    if (!$isunknown({a_in, b_in})) begin
      for (int i = 0; i < W; i++) begin
        p_sum_bcd_r2: assert (s_out[4*i +: 4] <= 4'd9)
          else $error("sum digit above nine");
      end
    end
  end
endmodule

// File: rtl/dec_ppgen.sv
module dec_ppgen
  import dec_ppgen_pkg::*;
#(
  parameter int DIGITS = 16
) (
  input  logic [4*DIGITS-1:0]     x_bcd,
  input  logic [3:0]              y_digit,
  output logic [4*(DIGITS+1)-1:0] pp_sum,
  output logic [DIGITS:0]         pp_carry
);
  localparam int VW = 4 * (DIGITS + 1);

  hi_sel_e         hi_sel;
  logic [1:0]      lo_mag;
  logic            lo_neg;
  logic [VW-1:0]   x_ext, x_dbl, x_five, x_ten, hi_term, lo_term;

  dec_ppgen_recode u_recode (
    .digit(y_digit), .hi_sel(hi_sel), .lo_mag(lo_mag), .lo_neg(lo_neg)
  );

  dec_ppgen_multiples #(.DIGITS(DIGITS)) u_mult (
    .x_bcd(x_bcd), .x_ext(x_ext), .x_dbl(x_dbl), .x_five(x_five), .x_ten(x_ten)
  );

  dec_ppgen_select #(.DIGITS(DIGITS)) u_sel (
    .hi_sel(hi_sel), .lo_mag(lo_mag), .lo_neg(lo_neg),
    .x_ext(x_ext), .x_dbl(x_dbl), .x_five(x_five), .x_ten(x_ten),
    .hi_term(hi_term), .lo_term(lo_term)
  );

  dec_ppgen_csa #(.DIGITS(DIGITS)) u_csa (
    .a_in(hi_term), .b_in(lo_term), .c_in(lo_neg),
    .s_out(pp_sum), .c_out(pp_carry)
  );

  always_comb begin
    if (!$isunknown({x_bcd, y_digit})) begin
      p_neg_unit_r3: assert (pp_carry[0] == (y_digit inside {4'd3, 4'd4, 4'd8, 4'd9}))
        else $error("carry bit 0 does not match digit sign");
      p_zero_digit_r4: assert (y_digit != 4'd0 || (pp_sum == '0 && pp_carry == '0))
        else $error("digit zero gave nonzero output");
      p_bad_digit_r7: assert (y_digit <= 4'd9 || (pp_sum == '0 && pp_carry == '0))
        else $error("invalid digit gave nonzero output");
      p_one_copy_r6: assert (y_digit != 4'd1 || (pp_sum == {4'd0, x_bcd} && pp_carry == '0))
        else $error("digit one did not copy the multiplicand");
    end
  end
endmodule

// File: tb/sim_dec_ppgen.sv
module sim_dec_ppgen;
  localparam int DIGITS = 16;
  localparam int W = DIGITS + 1;
  localparam longint unsigned MODV = 64'd100000000000000000; // 10^17

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [4*DIGITS-1:0] x_bcd;
  logic [3:0]          y_digit;
  logic [4*W-1:0]      pp_sum;
  logic [W-1:0]        pp_carry;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  dec_ppgen #(.DIGITS(DIGITS)) u0 (
    .x_bcd(x_bcd), .y_digit(y_digit), .pp_sum(pp_sum), .pp_carry(pp_carry)
  );

  function automatic longint unsigned bcd_val(input logic [4*DIGITS-1:0] v);
    longint unsigned r = 0;
    for (int i = DIGITS - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic longint unsigned pp_val(input logic [4*W-1:0] s, input logic [W-1:0] c);
    longint unsigned r = 0;
    longint unsigned w = 1;
    for (int i = 0; i < W; i++) begin
      r = r + w * (longint'(s[4*i +: 4]) + longint'(c[i]));
      w = w * 10;
    end
    return r % MODV;
  endfunction

  function automatic longint unsigned expect_val(input logic [4*DIGITS-1:0] x, input logic [3:0] d);
    return (d <= 4'd9) ? (bcd_val(x) * longint'(d)) : 64'd0;
  endfunction

  function automatic logic [4*W-1:0] five_digits(input logic [4*DIGITS-1:0] x);
    logic [4*W-1:0] r;
    logic [4*(W+1)-1:0] e;
    e = {8'd0, x};
    for (int i = 0; i < W; i++) begin
      int lo;
      int hi;
      lo = (i == 0) ? 0 : int'(e[4*(i-1) +: 4]) / 2;
      hi = 5 * (int'(e[4*i +: 4]) % 2);
      r[4*i +: 4] = 4'(lo + hi);
    end
    return r;
  endfunction

  task automatic apply(input logic [4*DIGITS-1:0] x, input logic [3:0] d);
    @(negedge clk);
    x_bcd   = x;
    y_digit = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (x=%h d=%0d)", req, act, exp, x_bcd, y_digit);
    end
  endtask

  task automatic check_common;
    longint unsigned got;
    bit digits_ok;
    bit neg;
    got = pp_val(pp_sum, pp_carry);
    check(got == expect_val(x_bcd, y_digit), "R1", got, expect_val(x_bcd, y_digit));
    digits_ok = 1'b1;
    for (int i = 0; i < W; i++) if (pp_sum[4*i +: 4] > 4'd9) digits_ok = 1'b0;
    check(digits_ok, "R2", 64'(digits_ok), 64'd1);
    neg = (y_digit == 4'd3 || y_digit == 4'd4 || y_digit == 4'd8 || y_digit == 4'd9);
    check(pp_carry[0] == neg, "R3", 64'(pp_carry[0]), 64'(neg));
  endtask

  function automatic logic [4*DIGITS-1:0] rand_x();
    logic [4*DIGITS-1:0] r;
    for (int i = 0; i < DIGITS; i++) r[4*i +: 4] = 4'($urandom % 10);
    return r;
  endfunction

  initial begin
    logic [4*DIGITS-1:0] xs;
    logic [4*DIGITS-1:0] nines;
    longint unsigned acc;
    void'($urandom(32'd20240517));
    nines = '1;
    for (int i = 0; i < DIGITS; i++) nines[4*i +: 4] = 4'd9;

    // idle state: zero inputs give zero outputs (R4)
    apply('0, 4'd0);
    check(pp_sum == '0 && pp_carry == '0, "R4", 64'(pp_sum != '0), 64'd0);

    // R4 with nonzero multiplicand
    apply(nines, 4'd0);
    check(pp_sum == '0 && pp_carry == '0, "R4", 64'(pp_carry), 64'd0);

    // R9: zero multiplicand, negative fine part, value wraps to zero
    for (int d = 8; d <= 9; d++) begin
      apply('0, 4'(d));
      check(pp_sum == {W{4'd9}} && pp_carry == W'(1), "R9", 64'(pp_carry), 64'd1);
      check_common();
    end

    // R8: doubling of all nines
    apply(nines, 4'd2);
    check(pp_carry == '0, "R8", 64'(pp_carry), 64'd0);
    check(pp_val(pp_sum, pp_carry) == bcd_val(nines) * 2, "R8",
          pp_val(pp_sum, pp_carry), bcd_val(nines) * 2);

    // R1 worked example: 1963 x 8145 rebuilt from four rows
    xs = '0;
    xs[15:0] = 16'h1963;
    acc = 0;
    apply(xs, 4'd5); acc = acc + pp_val(pp_sum, pp_carry);
    apply(xs, 4'd4); acc = acc + 10 * pp_val(pp_sum, pp_carry);
    apply(xs, 4'd1); acc = acc + 100 * pp_val(pp_sum, pp_carry);
    apply(xs, 4'd8); acc = acc + 1000 * pp_val(pp_sum, pp_carry);
    check(acc == 64'd15988635, "R1", acc, 64'd15988635);

    // R7: invalid digit codes with random and full multiplicands
    for (int d = 10; d <= 15; d++) begin
      apply((d % 2 == 0) ? nines : rand_x(), 4'(d));
      check(pp_sum == '0 && pp_carry == '0, "R7", 64'(pp_carry), 64'd0);
    end

    // alternating odd/even pattern for the five-times multiple (R5)
    xs = '0;
    for (int i = 0; i < DIGITS; i++) xs[4*i +: 4] = (i % 2 == 0) ? 4'd7 : 4'd4;
    apply(xs, 4'd5);
    check(pp_sum == five_digits(xs) && pp_carry == '0, "R5",
          pp_val(pp_sum, pp_carry), bcd_val(xs) * 5);

    // sweep all digits over directed and random multiplicands
    for (int t = 0; t < 300; t++) begin
      xs = (t == 0) ? nines : rand_x();
      for (int d = 0; d <= 9; d++) begin
        apply(xs, 4'(d));
        check_common();
        if (d == 1)
          check(pp_sum == {4'd0, xs} && pp_carry == '0, "R6",
                pp_val(pp_sum, pp_carry), bcd_val(xs));
        if (d == 5)
          check(pp_sum == five_digits(xs) && pp_carry == '0, "R5",
                pp_val(pp_sum, pp_carry), bcd_val(xs) * 5);
        if (d == 2)
          check(pp_carry == '0, "R8", 64'(pp_carry), 64'd0);
        if (d == 0)
          check(pp_sum == '0 && pp_carry == '0, "R4", 64'(pp_carry), 64'd0);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule